// File: doc/BRIEF.md
# Branch Target Pair Cache

This block sits beside the fetch unit and is looked up with the fetch address of a branch. When it hits, it returns the first two instructions of that branch's target stream. The fetch logic can then push those instructions into the instruction queue one cycle earlier than an instruction cache access would allow. Each entry holds the target instructions themselves, not a target address.

The cache holds 64 entries, arranged as 16 sets of 4 ways. A fill writes a branch address together with up to two target instruction words. Each word has its own valid flag, so a pair cut short by an unfetched boundary can be kept as a single instruction. Replacement keeps the most recently used targets. A single invalidate-all input clears the whole structure.

Top module: `bt_pair_cache`

## Requirements
- R1: The set index is `lk_addr[5:2]` (and `fill_addr[5:2]`). The tag is bits [31:6]. Bits [1:0] play no part in a match. Entries in different sets never affect each other.
- R2: The response to a lookup presented on clock edge N is visible on the `rsp_*` outputs after edge N. It reflects the contents as they were before any fill on that same edge.
- R3: On a hit, `rsp_hit` is 1 and `rsp_ins0`/`rsp_ins1` carry the two words of the most recent fill of that address. On a miss, `rsp_hit`, `rsp_v0` and `rsp_v1` are all 0.
- R4: A fill into a set that still has an empty way evicts no entry that is already present.
- R5: A fill of a new address into a full set evicts the entry whose last hit or fill is oldest.
- R6: A fill of an address already present overwrites that entry in place and never creates a second copy. The overwrite counts as a use of the entry for recency.
- R7: The flags `fill_v0` and `fill_v1` are stored per entry and returned as `rsp_v0` and `rsp_v1` on a hit.
- R8: `inv_all` empties every entry in one cycle, so every later lookup misses until a new fill. A fill on the same edge as `inv_all` is discarded.
- R9: After reset every lookup misses.
- R10: A cycle with `lk_valid` low gives `rsp_hit` = 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Branch fetch address to look up |
| fill_en | input | 1 | Write a target pair |
| fill_addr | input | ADDR_W | Branch address that owns the pair |
| fill_ins0 | input | INSTR_W | First target instruction |
| fill_ins1 | input | INSTR_W | Second target instruction |
| fill_v0 | input | 1 | First word present |
| fill_v1 | input | 1 | Second word present |
| inv_all | input | 1 | Empty the whole cache |
| rsp_hit | output | 1 | Registered hit flag |
| rsp_v0 | output | 1 | First returned word is valid |
| rsp_v1 | output | 1 | Second returned word is valid |
| rsp_ins0 | output | INSTR_W | First target instruction |
| rsp_ins1 | output | INSTR_W | Second target instruction |

## Verification
The bound checker checks several rules on every cycle:
- a miss never raises a slot flag;
- an idle cycle never produces a hit;
- a lookup right after `inv_all` misses;
- a lookup right after a fill of the same address hits with the filled data;
- no set ever matches one tag in two ways.

Victim choice under recency, in-place overwrite and per-slot flags only show up over sequences of fills and lookups. The bench's scenarios cover them, comparing every response against a separate reference model.

// File: rtl/btpc_pkg.sv
package btpc_pkg;

   // Which rule picked the way written by a fill
   typedef enum logic [1:0] {
      VS_MATCH = 2'd0,
      VS_FREE  = 2'd1,
      VS_LRU   = 2'd2
   } victim_src_e;

endpackage

// File: rtl/btpc_match.sv
module btpc_match #(
   parameter int TAG_W = 26,
   parameter int WAYS  = 4
) (
   input  logic [TAG_W-1:0] tag_i,
   input  logic [TAG_W-1:0] way_tag_i [WAYS],
   input  logic [WAYS-1:0]  way_val_i,
   output logic [WAYS-1:0]  hit_o
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_o[w] = way_val_i[w] && (way_tag_i[w] == tag_i);
   end

endmodule

// File: rtl/btpc_victim.sv
module btpc_victim
   import btpc_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int WAY_W = $clog2(WAYS),
   parameter int AGE_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  match_i,
   input  logic [WAYS-1:0]  val_i,
   input  logic [AGE_W-1:0] age_i [WAYS],
   output logic [WAY_W-1:0] way_o,
   output victim_src_e      src_o
);

   localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

   logic [WAY_W-1:0] match_w, free_w, old_w;

   always_comb begin
      match_w = '0;
      free_w  = '0;
      old_w   = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match_i[w])        match_w = WAY_W'(w);
         if (!val_i[w])         free_w  = WAY_W'(w);
         if (age_i[w] == OLDEST) old_w  = WAY_W'(w);
      end
   end

   always_comb begin
      if (|match_i) begin
         way_o = match_w;
         src_o = VS_MATCH;
      end else if (!(&val_i)) begin
         way_o = free_w;
         src_o = VS_FREE;
      end else begin
         way_o = old_w;
         src_o = VS_LRU;
      end
   end

endmodule

// File: rtl/btpc_age.sv
module btpc_age #(
   parameter int WAYS  = 4,
   parameter int WAY_W = $clog2(WAYS),
   parameter int AGE_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_i,
   input  logic [WAY_W-1:0] touch_way_i,
   output logic [AGE_W-1:0] age_o [WAYS]
);

   logic [AGE_W-1:0] age_q [WAYS];
   logic [AGE_W-1:0] ref_age;

   assign ref_age = age_q[touch_way_i];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            age_q[w] <= AGE_W'(w);
         end else if (touch_i) begin
            if (touch_way_i == WAY_W'(w))
               age_q[w] <= '0;
            else if (age_q[w] < ref_age)
               age_q[w] <= age_q[w] + 1'b1;
         end
      end
      assign age_o[w] = age_q[w];
   end

endmodule

// File: rtl/bt_pair_cache.sv
module bt_pair_cache
   import btpc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int INSTR_W = 32,
   parameter int ENTRIES = 64,
   parameter int WAYS    = 4,
   parameter int OFS_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [ADDR_W-1:0]  lk_addr,
   input  logic               fill_en,
   input  logic [ADDR_W-1:0]  fill_addr,
   input  logic [INSTR_W-1:0] fill_ins0,
   input  logic [INSTR_W-1:0] fill_ins1,
   input  logic               fill_v0,
   input  logic               fill_v1,
   input  logic               inv_all,
   output logic               rsp_hit,
   output logic               rsp_v0,
   output logic               rsp_v1,
   output logic [INSTR_W-1:0] rsp_ins0,
   output logic [INSTR_W-1:0] rsp_ins1
);

   localparam int SETS  = ENTRIES / WAYS;
   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int AGE_W = WAY_W;
   localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS * WAYS != ENTRIES || SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("ENTRIES / WAYS must be a power-of-two set count");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for index and offset");
   end

   // ---------------- storage ----------------
   logic [WAYS-1:0]    val_q  [SETS];
   logic [WAYS-1:0]    sv0_q  [SETS];
   logic [WAYS-1:0]    sv1_q  [SETS];
   logic [TAG_W-1:0]   tag_q  [SETS][WAYS];
   logic [INSTR_W-1:0] ins0_q [SETS][WAYS];
   logic [INSTR_W-1:0] ins1_q [SETS][WAYS];
   logic [AGE_W-1:0]   age_all[SETS][WAYS];

   // ---------------- lookup side ----------------
   logic [IDX_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag;
   logic [WAYS-1:0]  lk_hit_vec;
   logic [WAY_W-1:0] lk_way;
   logic             lk_any;

   assign lk_set = lk_addr[OFS_W +: IDX_W];
   assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];

   btpc_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lk_match (
      .tag_i     (lk_tag),
      .way_tag_i (tag_q[lk_set]),
      .way_val_i (val_q[lk_set]),
      .hit_o     (lk_hit_vec)
   );

   always_comb begin
      lk_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (lk_hit_vec[w]) lk_way = WAY_W'(w);
   end

   assign lk_any = lk_valid && (|lk_hit_vec);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_hit  <= 1'b0;
         rsp_v0   <= 1'b0;
         rsp_v1   <= 1'b0;
         rsp_ins0 <= '0;
         rsp_ins1 <= '0;
      end else begin
         rsp_hit  <= lk_any;
         rsp_v0   <= lk_any && sv0_q[lk_set][lk_way];
         rsp_v1   <= lk_any && sv1_q[lk_set][lk_way];
         rsp_ins0 <= ins0_q[lk_set][lk_way];
         rsp_ins1 <= ins1_q[lk_set][lk_way];
      end
   end

   // ---------------- fill side ----------------
   logic [IDX_W-1:0] f_set;
   logic [TAG_W-1:0] f_tag;
   logic [WAYS-1:0]  f_match;
   logic [WAY_W-1:0] f_way;
   victim_src_e      f_src;
   logic             fill_do;

   assign f_set   = fill_addr[OFS_W +: IDX_W];
   assign f_tag   = fill_addr[ADDR_W-1 -: TAG_W];
   assign fill_do = fill_en && !inv_all;

   btpc_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_fill_match (
      .tag_i     (f_tag),
      .way_tag_i (tag_q[f_set]),
      .way_val_i (val_q[f_set]),
      .hit_o     (f_match)
   );

   btpc_victim #(.WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_victim (
      .match_i (f_match),
      .val_i   (val_q[f_set]),
      .age_i   (age_all[f_set]),
      .way_o   (f_way),
      .src_o   (f_src)
   );

   // ---------------- recency, one tracker per set ----------------
   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic             touch;
      logic [WAY_W-1:0] touch_way;
      logic             fill_here;

      assign fill_here = fill_do && (f_set == IDX_W'(s));
      assign touch     = fill_here || (lk_any && (lk_set == IDX_W'(s)));
      assign touch_way = fill_here ? f_way : lk_way;

      btpc_age #(.WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_age (
         .clk         (clk),
         .rst_n       (rst_n),
         .touch_i     (touch),
         .touch_way_i (touch_way),
         .age_o       (age_all[s])
      );
   end

   // ---------------- state update ----------------
   always_ff @(posedge clk) begin
      if (!rst_n || inv_all) begin
         for (int s = 0; s < SETS; s++) val_q[s] <= '0;
      end else if (fill_en) begin
         val_q[f_set][f_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            sv0_q[s] <= '0;
            sv1_q[s] <= '0;
         end
      end else if (fill_do) begin
         sv0_q[f_set][f_way] <= fill_v0;
         sv1_q[f_set][f_way] <= fill_v1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_do) begin
         tag_q [f_set][f_way] <= f_tag;
         ins0_q[f_set][f_way] <= fill_ins0;
         ins1_q[f_set][f_way] <= fill_ins1;
      end
   end

   logic unused_src;
   assign unused_src = ^f_src;

endmodule

// File: rtl/btpc_chk.sv
module btpc_chk #(
   parameter int ADDR_W  = 32,
   parameter int INSTR_W = 32,
   parameter int WAYS    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [ADDR_W-1:0]  lk_addr,
   input logic               fill_en,
   input logic [ADDR_W-1:0]  fill_addr,
   input logic [INSTR_W-1:0] fill_ins0,
   input logic               inv_all,
   input logic               rsp_hit,
   input logic               rsp_v0,
   input logic               rsp_v1,
   input logic [INSTR_W-1:0] rsp_ins0,
   input logic [WAYS-1:0]    lk_hit_vec
);

   // R3
   miss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (!rsp_v0 && !rsp_v1));

   // R10
   idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_hit);

   // R8
   inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all ##1 lk_valid |=> !rsp_hit);

   // R2
   fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !inv_all) ##1 (lk_valid && lk_addr == $past(fill_addr))
      |=> (rsp_hit && rsp_ins0 == $past(fill_ins0, 2)));

   // R6
   single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $onehot0(lk_hit_vec));

endmodule

bind bt_pair_cache btpc_chk #(
   .ADDR_W  (ADDR_W),
   .INSTR_W (INSTR_W),
   .WAYS    (WAYS)
) u_btpc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_addr    (lk_addr),
   .fill_en    (fill_en),
   .fill_addr  (fill_addr),
   .fill_ins0  (fill_ins0),
   .inv_all    (inv_all),
   .rsp_hit    (rsp_hit),
   .rsp_v0     (rsp_v0),
   .rsp_v1     (rsp_v1),
   .rsp_ins0   (rsp_ins0),
   .lk_hit_vec (lk_hit_vec)
);

// File: tb/test_bt_pair_cache.sv
module test_bt_pair_cache;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        fill_en = 1'b0;
   logic [31:0] fill_addr = '0;
   logic [31:0] fill_ins0 = '0;
   logic [31:0] fill_ins1 = '0;
   logic        fill_v0 = 1'b0;
   logic        fill_v1 = 1'b0;
   logic        inv_all = 1'b0;
   logic        rsp_hit, rsp_v0, rsp_v1;
   logic [31:0] rsp_ins0, rsp_ins1;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   bt_pair_cache i_bt_pair_cache (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .fill_en(fill_en), .fill_addr(fill_addr),
      .fill_ins0(fill_ins0), .fill_ins1(fill_ins1),
      .fill_v0(fill_v0), .fill_v1(fill_v1),
      .inv_all(inv_all),
      .rsp_hit(rsp_hit), .rsp_v0(rsp_v0), .rsp_v1(rsp_v1),
      .rsp_ins0(rsp_ins0), .rsp_ins1(rsp_ins1)
   );

   typedef struct {
      bit          hit;
      bit          v0;
      bit          v1;
      logic [31:0] i0;
      logic [31:0] i1;
      string       req;
   } exp_t;

   exp_t q[$];

   // reference model
   bit          m_val[16][4];
   logic [25:0] m_tag[16][4];
   logic [31:0] m_i0[16][4];
   logic [31:0] m_i1[16][4];
   bit          m_v0[16][4];
   bit          m_v1[16][4];
   int          m_age[16][4];

   function automatic logic [31:0] adr(int tag, int set);
      return (32'(tag) << 6) | (32'(set) << 2);
   endfunction

   task automatic m_touch(int s, int w);
      int ref_a = m_age[s][w];
      for (int x = 0; x < 4; x++)
         if (x != w && m_age[s][x] < ref_a) m_age[s][x]++;
      m_age[s][w] = 0;
   endtask

   task automatic chk(string req, bit ok, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step(bit lk, logic [31:0] la, bit fe, logic [31:0] fa,
                       logic [31:0] d0, logic [31:0] d1, bit fv0, bit fv1,
                       bit inv, string req);
      exp_t e;
      int ls, fs, hw, vw;
      logic [25:0] lt, ft;
      @(negedge clk);
      lk_valid = lk; lk_addr = la; fill_en = fe; fill_addr = fa;
      fill_ins0 = d0; fill_ins1 = d1; fill_v0 = fv0; fill_v1 = fv1; inv_all = inv;
      ls = int'(la[5:2]); lt = la[31:6];
      fs = int'(fa[5:2]); ft = fa[31:6];
      hw = -1;
      e.hit = 0; e.v0 = 0; e.v1 = 0; e.i0 = '0; e.i1 = '0; e.req = req;
      if (lk)
         for (int w = 0; w < 4; w++)
            if (m_val[ls][w] && m_tag[ls][w] == lt) hw = w;
      if (hw >= 0) begin
         e.hit = 1; e.v0 = m_v0[ls][hw]; e.v1 = m_v1[ls][hw];
         e.i0 = m_i0[ls][hw]; e.i1 = m_i1[ls][hw];
      end
      q.push_back(e);
      if (hw >= 0 && !(fe && !inv && fs == ls)) m_touch(ls, hw);
      if (inv) begin
         for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++) m_val[s][w] = 0;
      end else if (fe) begin
         vw = -1;
         for (int w = 0; w < 4; w++)
            if (m_val[fs][w] && m_tag[fs][w] == ft) vw = w;
         if (vw < 0)
            for (int w = 3; w >= 0; w--) if (!m_val[fs][w]) vw = w;
         if (vw < 0)
            for (int w = 0; w < 4; w++) if (m_age[fs][w] == 3) vw = w;
         m_val[fs][vw] = 1; m_tag[fs][vw] = ft;
         m_i0[fs][vw] = d0; m_i1[fs][vw] = d1;
         m_v0[fs][vw] = fv0; m_v1[fs][vw] = fv1;
         m_touch(fs, vw);
      end
   endtask

   task automatic look(logic [31:0] a, string req);
      step(1, a, 0, '0, '0, '0, 0, 0, 0, req);
   endtask

   task automatic fill(logic [31:0] a, logic [31:0] d0, logic [31:0] d1, bit v0, bit v1);
      step(0, '0, 1, a, d0, d1, v0, v1, 0, "fill");
   endtask

   // monitor: response of the lookup driven before edge N is read just after edge N
   always @(posedge clk) begin
      #1;
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(e.req, rsp_hit == e.hit, "hit", 32'(rsp_hit), 32'(e.hit));
         if (e.hit) begin
            chk(e.req, rsp_v0 == e.v0 && rsp_v1 == e.v1, "slot flags",
                32'({rsp_v0, rsp_v1}), 32'({e.v0, e.v1}));
            chk(e.req, rsp_ins0 == e.i0 && rsp_ins1 == e.i1, "ins0",
                rsp_ins0, e.i0);
         end else if (e.req != "fill") begin
            chk(e.req, !rsp_v0 && !rsp_v1, "miss flags",
                32'({rsp_v0, rsp_v1}), 32'h0);
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int s = 0; s < 16; s++)
         for (int w = 0; w < 4; w++) begin
            m_val[s][w] = 0; m_age[s][w] = w;
            m_v0[s][w] = 0; m_v1[s][w] = 0;
         end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      chk("R9", !rsp_hit && !rsp_v0 && !rsp_v1, "reset outputs",
          32'({rsp_hit, rsp_v0, rsp_v1}), 32'h0);
      look(adr(1, 3), "R9");

      fill(adr(1, 3), 32'hA001_0003, 32'hB001_0003, 1, 1);
      look(adr(1, 3), "R3");
      // R2: lookup and fill on the same edge sees the old contents
      step(1, adr(2, 3), 1, adr(2, 3), 32'hA002_0003, 32'hB002_0003, 1, 1, 0, "R2");
      look(adr(2, 3), "R2");

      // R4: remaining free ways fill without eviction
      fill(adr(3, 3), 32'hA003_0003, 32'hB003_0003, 1, 1);
      fill(adr(4, 3), 32'hA004_0003, 32'hB004_0003, 1, 1);
      for (int t = 1; t <= 4; t++) look(adr(t, 3), "R4");

      // R5: recency decides the victim (tag 2 is oldest here)
      look(adr(1, 3), "R5");
      fill(adr(5, 3), 32'hA005_0003, 32'hB005_0003, 1, 1);
      look(adr(2, 3), "R5");
      look(adr(1, 3), "R5");
      look(adr(3, 3), "R5");
      look(adr(4, 3), "R5");
      look(adr(5, 3), "R5");

      // R6: refill in place, then a new fill evicts the oldest other entry
      fill(adr(3, 3), 32'hC003_0003, 32'hD003_0003, 1, 1);
      look(adr(3, 3), "R6");
      fill(adr(6, 3), 32'hA006_0003, 32'hB006_0003, 1, 1);
      look(adr(1, 3), "R6");
      look(adr(3, 3), "R6");
      look(adr(6, 3), "R6");

      // R7: per-slot flags
      fill(adr(7, 9), 32'hA007_0009, 32'hB007_0009, 1, 0);
      look(adr(7, 9), "R7");
      fill(adr(8, 9), 32'hA008_0009, 32'hB008_0009, 0, 1);
      look(adr(8, 9), "R7");

      // R1: sets are independent and low offset bits are ignored
      fill(adr(3, 4), 32'hE003_0004, 32'hF003_0004, 1, 1);
      look(adr(3, 3), "R1");
      look(adr(3, 4) | 32'h3, "R1");

      // R10: idle cycle while the address would hit
      step(0, adr(3, 3), 0, '0, '0, '0, 0, 0, 0, "R10");

      // R8: invalidate-all, with a fill on the same edge
      step(0, '0, 1, adr(9, 5), 32'hA009_0005, 32'hB009_0005, 1, 1, 1, "R8");
      look(adr(3, 3), "R8");
      look(adr(6, 3), "R8");
      look(adr(9, 5), "R8");
      fill(adr(9, 5), 32'hA009_0005, 32'hB009_0005, 1, 1);
      look(adr(9, 5), "R8");

      step(0, '0, 0, '0, '0, '0, 0, 0, 0, "R10");
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule